// File: doc/BRIEF.md
# Time-Space Multiply Operand Encoder

This block drives an array of 64 on/off light emitters so that an analog summing detector, reading the combined current of all emitters, forms a signed inner product of two integer vectors. The first operand of each element is carried in time: inside a frame of 100 clock slots, the element's emitters may light only during the first `a` slots. The second operand is carried in space: each element owns a set of emitters whose on/off pattern is the binary magnitude of `b`. The set is split into a positive half and a negative half, and only the half that matches the sign of `b` is used. Each emitter's enable is the AND of its spatial bit and its set's time-active signal.

Software first fills an operand store through a simple write port, one element (both operands) per write. It then pulses `start` with a precision mode and a vector length. The mode sets the set size and so the number of elements per frame. A vector longer than one frame is sent as successive chunks in back-to-back frames. A one-cycle `frame_done` strobe marks the end of every frame so that an external converter can sample the summed current. The sequencer has three states: `SEQ_IDLE` (nothing lit), `SEQ_RUN` (a frame that is not the last) and `SEQ_FINAL` (the last frame). Its transitions are LAUNCH (`SEQ_IDLE` to `SEQ_RUN` or to `SEQ_FINAL` on an accepted start), NEXT (`SEQ_RUN` to `SEQ_RUN` at a frame end while two or more frames remain), LAST (`SEQ_RUN` to `SEQ_FINAL` at the frame end before the final frame) and RETIRE (`SEQ_FINAL` to `SEQ_IDLE` at the end of the final frame).

Top module: `ts_encoder`

## Requirements
- R1: After reset, and whenever `busy` is low, all of `emit_en`, `frame_done` and `busy` are 0.
- R2: A frame lasts exactly 100 cycles, with the slot number running from 0 to 99. `frame_done` is high only in slot 99 of each frame, for one cycle.
- R3: In a frame, an element's emitters can be on only in slots 0 to a-1. With a=0 they are never on. With a of 100 or more they may be on in all 100 slots.
- R4: Set s covers emitters s*2M to s*2M+2M-1. Its lower M emitters form the positive group and its upper M emitters form the negative group. Group emitter k (offset k in the group) carries weight 2^k and is on exactly when bit k of |b| is 1.
- R5: When b >= 0, only the positive group is used. When b < 0, only the negative group is used. The other group stays fully off.
- R6: Only the low M bits of |b| are used. If these bits are zero (including b=0, or b=-4 in 2-bit mode), the whole set stays off whatever the sign.
- R7: `cfg_mode` encoding: 0 gives M=2 (16 sets), 1 gives M=4 (8 sets), 2 and 3 give M=8 (4 sets).
- R8: With S sets, frame p presents elements p*S to p*S+S-1 in set order. The frames follow each other with no gap until ceil(L/S) frames are done. L is `cfg_len` limited to 64.
- R9: In the last frame, sets whose element index is L or more stay fully off.
- R10: `busy` rises the cycle after an accepted start and falls right after the last frame. This gives ceil(L/S)*100 busy cycles.
- R11: The element store, `cfg_mode` and `cfg_len` are sampled at an accepted start. Writes and config changes during a run do not affect that run, and do take effect at the next start.
- R12: A start while `busy` is high is ignored. A start with `cfg_len` = 0 is ignored.
- R13: With `wr_en` high, a write stores `wr_a` and the two's complement `wr_b` as element `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Element write strobe |
| wr_addr | input | 6 | Element index to write |
| wr_a | input | 7 | First operand (time-coded duty, 0..100) |
| wr_b | input | 9 | Second operand, two's complement |
| cfg_mode | input | 2 | Precision mode, sampled at start |
| cfg_len | input | 7 | Vector length, sampled at start |
| start | input | 1 | Start strobe |
| emit_en | output | 64 | Emitter enables |
| frame_done | output | 1 | One-cycle end-of-frame strobe |
| busy | output | 1 | High while a run is in progress |

## Verification
The hardest condition to reach from the ports is a run whose stored operands and configuration change while it is still in progress. The bench launches a run and then, during that run, rewrites several elements, changes the mode and the length, and pulses start again. The scoreboard still holds the frames built from the values captured at launch, so any leak of the new values, and any extra frame caused by the second start, shows up as a per-slot emitter mismatch. A follow-up run then has to show the rewritten values, and further runs reach the partial last frame and lengths above 64.

// File: rtl/ts_encoder_pkg.sv
package ts_encoder_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_FINAL = 2'd2
    } seq_state_e;

    // log2 of the emitter count of one set for a precision mode
    function automatic int unsigned set_log2(input logic [1:0] mode);
        case (mode)
            2'd0:    return 2;
            2'd1:    return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/ts_operand_bank.sv
module ts_operand_bank #(
    parameter int MAX_LEN = 64,
    parameter int A_W     = 7,
    parameter int B_W     = 9,
    localparam int ADDR_W = $clog2(MAX_LEN)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [A_W-1:0]                  wr_a,
    input  logic [B_W-1:0]                  wr_b,
    input  logic                            capture,
    output logic [MAX_LEN-1:0][A_W-1:0]     work_a,
    output logic [MAX_LEN-1:0][B_W-1:0]     work_b
);

    logic [MAX_LEN-1:0][A_W-1:0] stage_a;
    logic [MAX_LEN-1:0][B_W-1:0] stage_b;

    // software-facing staging copy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_a <= '0;
            stage_b <= '0;
        end else if (wr_en) begin
            stage_a[wr_addr] <= wr_a;
            stage_b[wr_addr] <= wr_b;
        end
    end

    // working copy, frozen for the whole run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_a <= '0;
            work_b <= '0;
        end else if (capture) begin
            work_a <= stage_a;
            work_b <= stage_b;
        end
    end

endmodule

// File: rtl/ts_sequencer.sv
module ts_sequencer
    import ts_encoder_pkg::*;
#(
    parameter int NUM_EMIT    = 64,
    parameter int FRAME_SLOTS = 100,
    parameter int MAX_LEN     = 64,
    localparam int SLOT_W     = $clog2(FRAME_SLOTS),
    localparam int LEN_W      = $clog2(MAX_LEN + 1),
    localparam int CNT_W      = $clog2(MAX_LEN + NUM_EMIT) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cfg_mode,
    input  logic [LEN_W-1:0]  cfg_len,
    output logic              launch,
    output logic              active,
    output logic              frame_done,
    output logic [1:0]        mode_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [CNT_W-1:0]  base_q,
    output logic [SLOT_W-1:0] slot_q
);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  sets_cur, sets_new;
    logic [LEN_W-1:0]  len_clip;
    logic              frame_end;
    logic              busy_w;

    assign len_clip  = (cfg_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : cfg_len;
    assign sets_new  = CNT_W'(NUM_EMIT >> set_log2(cfg_mode));
    assign sets_cur  = CNT_W'(NUM_EMIT >> set_log2(mode_q));
    assign busy_w    = (state_q != SEQ_IDLE);
    assign frame_end = busy_w && (slot_q == SLOT_W'(FRAME_SLOTS - 1));
    assign launch    = (state_q == SEQ_IDLE) && start && (len_clip != '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (launch)
                    state_d = (CNT_W'(len_clip) <= sets_new) ? SEQ_FINAL : SEQ_RUN;
            end
            SEQ_RUN: begin
                if (frame_end)
                    state_d = ((base_q + (sets_cur << 1)) >= CNT_W'(len_q)) ? SEQ_FINAL : SEQ_RUN;
            end
            SEQ_FINAL: begin
                if (frame_end)
                    state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // slot counter, chunk base and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            base_q <= '0;
            len_q  <= '0;
            mode_q <= 2'd0;
        end else if (launch) begin
            slot_q <= '0;
            base_q <= '0;
            len_q  <= len_clip;
            mode_q <= cfg_mode;
        end else if (frame_end) begin
            slot_q <= '0;
            base_q <= (state_q == SEQ_RUN) ? (base_q + sets_cur) : '0;
        end else if (busy_w) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        active     = busy_w;
        frame_done = frame_end;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R2

    AST_RUN_FROM_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_w) |-> (slot_q == '0)); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && start && !frame_end) |=> busy_w); // R12

    AST_CONFIG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |=> ($stable(mode_q) && $stable(len_q))); // R11

endmodule

// File: rtl/ts_window.sv
module ts_window #(
    parameter int MAX_LEN  = 64,
    parameter int MAX_SETS = 16,
    parameter int A_W      = 7,
    parameter int B_W      = 9,
    parameter int LEN_W    = 7,
    parameter int CNT_W    = 8,
    localparam int ADDR_W  = $clog2(MAX_LEN)
) (
    input  logic [MAX_LEN-1:0][A_W-1:0]  work_a,
    input  logic [MAX_LEN-1:0][B_W-1:0]  work_b,
    input  logic [CNT_W-1:0]             base,
    input  logic [LEN_W-1:0]             len,
    output logic [MAX_SETS-1:0][A_W-1:0] win_a,
    output logic [MAX_SETS-1:0][B_W-1:0] win_b,
    output logic [MAX_SETS-1:0]          win_valid
);

    // one selector per set position gathers the current chunk
    for (genvar j = 0; j < MAX_SETS; j++) begin : g_pos
        logic [CNT_W-1:0] idx;
        assign idx          = base + CNT_W'(j);
        assign win_valid[j] = (idx < CNT_W'(len));
        assign win_a[j]     = win_valid[j] ? work_a[idx[ADDR_W-1:0]] : '0;
        assign win_b[j]     = win_valid[j] ? work_b[idx[ADDR_W-1:0]] : '0;
    end

endmodule

// File: rtl/ts_emitter_map.sv
module ts_emitter_map #(
    parameter int NUM_EMIT = 64,
    parameter int MAX_SETS = 16,
    parameter int A_W      = 7,
    parameter int B_W      = 9,
    parameter int SLOT_W   = 7,
    localparam int CMP_W   = (A_W > SLOT_W) ? A_W : SLOT_W
) (
    input  logic [1:0]                   mode,
    input  logic                         active,
    input  logic [SLOT_W-1:0]            slot,
    input  logic [MAX_SETS-1:0][A_W-1:0] win_a,
    input  logic [MAX_SETS-1:0][B_W-1:0] win_b,
    input  logic [MAX_SETS-1:0]          win_valid,
    output logic [NUM_EMIT-1:0]          emit_en
);

    logic [MAX_SETS-1:0]            set_neg;
    logic [MAX_SETS-1:0]            set_pwm;
    logic [MAX_SETS-1:0][B_W-2:0]   set_mag;

    // per set: sign, magnitude and time-active flag
    for (genvar j = 0; j < MAX_SETS; j++) begin : g_set
        assign set_neg[j] = win_b[j][B_W-1];
        assign set_mag[j] = set_neg[j] ? (~win_b[j][B_W-2:0] + 1'b1) : win_b[j][B_W-2:0];
        assign set_pwm[j] = active && win_valid[j] && (CMP_W'(slot) < CMP_W'(win_a[j]));
    end

    // per emitter: fixed geometry for each precision mode
    for (genvar e = 0; e < NUM_EMIT; e++) begin : g_emit
        localparam int S2 = e / 4;
        localparam int K2 = (e % 4) % 2;
        localparam bit N2 = ((e % 4) >= 2);
        localparam int S4 = e / 8;
        localparam int K4 = (e % 8) % 4;
        localparam bit N4 = ((e % 8) >= 4);
        localparam int S8 = e / 16;
        localparam int K8 = (e % 16) % 8;
        localparam bit N8 = ((e % 16) >= 8);

        always_comb begin
            unique case (mode)
                2'd0:    emit_en[e] = set_pwm[S2] & set_mag[S2][K2] & (set_neg[S2] == N2);
                2'd1:    emit_en[e] = set_pwm[S4] & set_mag[S4][K4] & (set_neg[S4] == N4);
                default: emit_en[e] = set_pwm[S8] & set_mag[S8][K8] & (set_neg[S8] == N8);
            endcase
        end
    end

endmodule

// File: rtl/ts_encoder.sv
module ts_encoder
    import ts_encoder_pkg::*;
#(
    parameter int NUM_EMIT    = 64,
    parameter int FRAME_SLOTS = 100,
    parameter int MAX_LEN     = 64,
    parameter int A_W         = 7,
    parameter int B_W         = 9,
    localparam int ADDR_W     = $clog2(MAX_LEN),
    localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [A_W-1:0]      wr_a,
    input  logic [B_W-1:0]      wr_b,
    input  logic [1:0]          cfg_mode,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                start,
    output logic [NUM_EMIT-1:0] emit_en,
    output logic                frame_done,
    output logic                busy
);

    localparam int MAX_SETS = NUM_EMIT / 4;
    localparam int SLOT_W   = $clog2(FRAME_SLOTS);
    localparam int CNT_W    = $clog2(MAX_LEN + NUM_EMIT) + 1;

    logic                            launch;
    logic                            active;
    logic [1:0]                      mode_q;
    logic [LEN_W-1:0]                len_q;
    logic [CNT_W-1:0]                base_q;
    logic [SLOT_W-1:0]               slot_q;
    logic [MAX_LEN-1:0][A_W-1:0]     work_a;
    logic [MAX_LEN-1:0][B_W-1:0]     work_b;
    logic [MAX_SETS-1:0][A_W-1:0]    win_a;
    logic [MAX_SETS-1:0][B_W-1:0]    win_b;
    logic [MAX_SETS-1:0]             win_valid;

    ts_operand_bank #(.MAX_LEN(MAX_LEN), .A_W(A_W), .B_W(B_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .capture (launch),
        .work_a  (work_a),
        .work_b  (work_b)
    );

    ts_sequencer #(.NUM_EMIT(NUM_EMIT), .FRAME_SLOTS(FRAME_SLOTS), .MAX_LEN(MAX_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_mode   (cfg_mode),
        .cfg_len    (cfg_len),
        .launch     (launch),
        .active     (active),
        .frame_done (frame_done),
        .mode_q     (mode_q),
        .len_q      (len_q),
        .base_q     (base_q),
        .slot_q     (slot_q)
    );

    ts_window #(.MAX_LEN(MAX_LEN), .MAX_SETS(MAX_SETS), .A_W(A_W), .B_W(B_W),
                .LEN_W(LEN_W), .CNT_W(CNT_W)) u_win (
        .work_a    (work_a),
        .work_b    (work_b),
        .base      (base_q),
        .len       (len_q),
        .win_a     (win_a),
        .win_b     (win_b),
        .win_valid (win_valid)
    );

    ts_emitter_map #(.NUM_EMIT(NUM_EMIT), .MAX_SETS(MAX_SETS), .A_W(A_W), .B_W(B_W),
                     .SLOT_W(SLOT_W)) u_map (
        .mode      (mode_q),
        .active    (active),
        .slot      (slot_q),
        .win_a     (win_a),
        .win_b     (win_b),
        .win_valid (win_valid),
        .emit_en   (emit_en)
    );

    assign busy = active;

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((emit_en == '0) && !frame_done)); // R1

endmodule

// File: tb/ts_encoder_bench.sv
module ts_encoder_bench;

    localparam int NE = 64;
    localparam int NS = 100;

    typedef struct packed {
        logic [NE-1:0]   mask;
        logic [NE*7-1:0] duty;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [6:0] wr_a = '0;
    logic [8:0] wr_b = '0;
    logic [1:0] cfg_mode = '0;
    logic [6:0] cfg_len = '0;
    logic       start = 1'b0;
    logic [NE-1:0] emit_en;
    logic       frame_done;
    logic       busy;

    int checks = 0;
    int fails = 0;
    int pcnt = 0;
    int sa [NE];
    int sb [NE];
    item_t q [$];
    string cur_req = "R1";
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) pcnt++;

    ts_encoder u_ts_encoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_a(wr_a),
        .wr_b(wr_b), .cfg_mode(cfg_mode), .cfg_len(cfg_len), .start(start),
        .emit_en(emit_en), .frame_done(frame_done), .busy(busy)
    );

    function automatic item_t build_item(int mode, int len, int pass);
        item_t it;
        int gb, setw, nsets, s, pos, k, idx, b, mag, du;
        bit neg;
        it = '0;
        gb = (mode == 0) ? 2 : (mode == 1) ? 4 : 8;
        setw = 2 * gb;
        nsets = NE / setw;
        for (int e = 0; e < NE; e++) begin
            s = e / setw; pos = e % setw; k = pos % gb; neg = (pos >= gb);
            idx = pass * nsets + s;
            if (idx < len) begin
                b = sb[idx];
                mag = ((b < 0) ? -b : b) & ((1 << gb) - 1);
                it.mask[e] = ((mag >> k) & 1) == 1 && ((b < 0) == neg);
                du = (sa[idx] > 100) ? 100 : sa[idx];
                it.duty[e*7 +: 7] = 7'(du);
            end
        end
        return it;
    endfunction

    task automatic put(int addr, int a, int b);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(addr); wr_a = 7'(a); wr_b = 9'(b);
        sa[addr] = a; sb[addr] = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes expected frames, pulses start; returns frame count and launch time
    task automatic launch(int mode, int len, string req, output int npass, output int t0);
        int l, nsets;
        l = (len > NE) ? NE : len;
        nsets = NE / ((mode == 0) ? 4 : (mode == 1) ? 8 : 16);
        npass = (l + nsets - 1) / nsets;
        cur_req = req;
        for (int p = 0; p < npass; p++) q.push_back(build_item(mode, l, p));
        @(negedge clk);
        cfg_mode = 2'(mode); cfg_len = 7'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0 = pcnt;
        checks++;
        if (busy !== 1'b1) begin
            fails++;
            $display("FAIL R10 busy after start: got %0b expected 1", busy);
        end
    endtask

    task automatic wait_done(int npass, int t0, string req);
        while (busy === 1'b1) @(negedge clk);
        checks++;
        if ((pcnt - t0) != npass * NS || q.size() != 0) begin
            fails++;
            $display("FAIL %s R8 R10 run length: got %0d cycles, %0d frames left; expected %0d cycles, 0 left",
                     req, pcnt - t0, q.size(), npass * NS);
        end
    endtask

    task automatic job(int mode, int len, string req);
        int np, t0;
        launch(mode, len, req, np, t0);
        wait_done(np, t0, req);
    endtask

    // monitor: per-slot compare against the scoreboard frame
    int fslot = 0;
    item_t cur;
    bit bad = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy === 1'b1) begin
                if (fslot == 0) begin
                    bad = 1'b0;
                    if (q.size() == 0) begin
                        cur = '0;
                        bad = 1'b1;
                        checks++; fails++;
                        $display("FAIL R12 unexpected frame: got busy=1 expected no frame");
                    end else begin
                        cur = q.pop_front();
                    end
                end
                for (int e = 0; e < NE; e++) begin
                    logic exp_b;
                    exp_b = cur.mask[e] && (fslot < int'(cur.duty[e*7 +: 7]));
                    if (emit_en[e] !== exp_b && !bad) begin
                        bad = 1'b1;
                        $display("FAIL %s emitter %0d slot %0d: got %0b expected %0b",
                                 cur_req, e, fslot, emit_en[e], exp_b);
                    end
                end
                if (frame_done !== (fslot == NS - 1) && !bad) begin
                    bad = 1'b1;
                    $display("FAIL R2 frame_done slot %0d: got %0b expected %0b",
                             fslot, frame_done, fslot == NS - 1);
                end
                if (fslot == NS - 1) begin
                    checks++;
                    if (bad) fails++;
                    fslot = 0;
                end else begin
                    fslot++;
                end
            end else begin
                fslot = 0;
                if (emit_en !== '0 || frame_done !== 1'b0) begin
                    checks++; fails++;
                    $display("FAIL R1 idle outputs: got emit=%h done=%0b expected 0 0", emit_en, frame_done);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int np, t0;
        for (int i = 0; i < NE; i++) begin sa[i] = 0; sb[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (emit_en !== '0 || busy !== 1'b0 || frame_done !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got emit=%h busy=%0b done=%0b expected 0 0 0", emit_en, busy, frame_done);
        end

        // 4-bit mode, one frame: duty edges, signs, zero
        put(0, 0, 5);   put(1, 100, -15); put(2, 37, 15); put(3, 1, 0);
        put(4, 99, -1); put(5, 50, -8);   put(6, 120, 10); put(7, 64, -6);
        job(1, 8, "R3 R4 R5 R6 R13");

        // 2-bit mode, out-of-range magnitudes
        for (int i = 0; i < 16; i++) put(i, i * 6 + 3, (i % 9) - 4);
        job(0, 16, "R6 R7");

        // 8-bit modes 2 and 3
        put(0, 80, 255); put(1, 45, -255); put(2, 100, -256); put(3, 7, 128);
        job(2, 4, "R4 R7");
        job(3, 4, "R7");

        // multi-pass with partial last frame
        for (int i = 0; i < 20; i++) put(i, (i * 13) % 101, ((i * 7) % 31) - 15);
        job(1, 20, "R8 R9");

        // full length, 2-bit mode
        for (int i = 0; i < NE; i++) put(i, (i * 29) % 110, ((i * 5) % 7) - 3);
        job(0, 64, "R8");

        // length above 64 limited to 64
        job(2, 70, "R8 R10");

        // changes during a run are ignored; second start ignored
        launch(1, 8, "R11 R12", np, t0);
        put(0, 90, -7); put(1, 10, 3); put(2, 55, -12); put(3, 100, 9);
        cfg_mode = 2'd0; cfg_len = 7'd64;
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done(np, t0, "R11 R12");
        job(1, 8, "R11 new values");

        // zero-length start ignored
        @(negedge clk);
        cfg_len = 7'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (busy !== 1'b0) begin
            fails++;
            $display("FAIL R12 zero length: got busy=%0b expected 0", busy);
        end

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule